// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output-compare channel that sits beside a timer counter. It holds a compare value and checks it against the counter value on each cycle in which the timer advances. When the two match, it drives an internal compare output bit through an action picked by a two-bit mode field (toggle, clear or set), and it raises a sticky match flag. Software can also apply the mode's action at any time by pulsing a force strobe. This strobe does not touch the flag.

The block guards against false events after software reloads the counter. A CPU write to the counter arms a one-tick blocking window, so the next timer tick cannot produce a match. The window waits for that tick however long the timer stays stopped. As a result, loading the compare register with the value just written to the counter produces no event when the timer starts. The mode field is not buffered. It controls the pin routing in the same cycle it changes, and the next action uses its current value. A port-direction bit enables the pin. When the mode is non-zero the compare bit drives the pin. When the mode is zero the port data register drives it.

Top module: `oc_compare_unit`

## Requirements
- R1: After reset the compare output bit, the match flag, the compare register and the blocking window are all zero.
- R2: A compare write (`cmp_wr`) loads `cmp_wdata`, and `cmp_val` shows it from the next cycle.
- R3: A match occurs only in a cycle with `tick` high where `cnt_val` equals the compare register and no block applies. A match sets `match_flag` and applies the mode action to `oc_state`, both visible the cycle after.
- R4: Mode encoding: 00 leaves `oc_state` unchanged, 01 inverts it, 10 clears it, 11 sets it.
- R5: A cycle with `cnt_wr` high cannot match. The first `tick` after it cannot match either, however many idle cycles pass between them. The tick after that matches normally.
- R6: A `force_oc` pulse applies the current mode action to `oc_state` the next cycle. It never sets `match_flag`, and a pending block does not affect it.
- R7: `flag_clr` high clears `match_flag` in the next cycle, unless a match occurs in the same cycle, in which case the flag stays set.
- R8: A change of `oc_mode` changes the pin source combinationally, in the same cycle, with no buffering.
- R9: `pin_oe` equals `port_dir`. With `port_dir` low, `pin_out` is 0. With it high, `pin_out` is `oc_state` when the mode is non-zero and `port_data` when the mode is 00.
- R10: Without a match or force, `oc_state` keeps its value across any change of `oc_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer advance enable for this cycle |
| cnt_val | input | CNT_W | Current counter value |
| cnt_wr | input | 1 | CPU write to the counter this cycle |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W | Compare register write data |
| oc_mode | input | 2 | Compare output mode field |
| force_oc | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear for the match flag |
| port_data | input | 1 | General port data register bit |
| port_dir | input | 1 | Port direction bit, 1 = output |
| cmp_val | output | CNT_W | Compare register contents |
| oc_state | output | 1 | Internal compare output bit |
| match_flag | output | 1 | Sticky match flag |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench builds the block with `CNT_W=4`. At that width, every pairing of compare value and counter value, 256 in all, can be swept, so both the equality path and every mismatch path are covered. The pin routing has only 32 combinations of direction, mode, port data and compare bit, and the bench checks all of them. Each mode action is checked from both starting values of the compare bit. The blocking window is driven with a stopped timer, with a write and a tick in the same cycle, and together with force pulses.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [1:0] {
    OCM_OFF    = 2'b00,
    OCM_TOGGLE = 2'b01,
    OCM_CLEAR  = 2'b10,
    OCM_SET    = 2'b11
  } oc_mode_e;

  // Value the compare bit takes when an event (match or force) hits it.
  function automatic logic oc_action(input logic [1:0] mode, input logic cur);
    logic nxt;
    case (mode)
      OCM_TOGGLE: nxt = ~cur;
      OCM_CLEAR:  nxt = 1'b0;
      OCM_SET:    nxt = 1'b1;
      default:    nxt = cur;
    endcase
    return nxt;
  endfunction

  // Non-zero mode hands the pin over to the compare bit.
  function automatic logic oc_owns_pin(input logic [1:0] mode);
    return mode != OCM_OFF;
  endfunction

endpackage

// File: rtl/oc_match_gate.sv
module oc_match_gate #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cmp_val,
  output logic             hit
);

  logic [CNT_W-1:0] cmp_q;
  logic             block_q;
  logic             equal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_wr) begin
      cmp_q <= cmp_wdata;
    end
  end

  // Blocking window: armed by a counter write, consumed by the next tick.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      block_q <= 1'b0;
    end else if (cnt_wr) begin
      block_q <= 1'b1;
    end else if (tick) begin
      block_q <= 1'b0;
    end
  end

  assign equal   = (cnt_val == cmp_q);
  assign hit     = tick & equal & ~block_q & ~cnt_wr;
  assign cmp_val = cmp_q;

endmodule

// File: rtl/oc_state_reg.sv
module oc_state_reg
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       hit,
  input  logic       force_oc,
  input  logic       flag_clr,
  output logic       oc_q,
  output logic       flag_q
);

  logic apply;

  assign apply = hit | force_oc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc_q <= 1'b0;
    end else if (apply) begin
      oc_q <= oc_action(mode, oc_q);
    end
  end

  // A match in the same cycle wins over the clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (hit) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/oc_pin_mux.sv
module oc_pin_mux
  import oc_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       oc_q,
  input  logic       port_data,
  input  logic       port_dir,
  output logic       pin_out,
  output logic       pin_oe
);

  logic src;

  assign src     = oc_owns_pin(mode) ? oc_q : port_data;
  assign pin_out = port_dir & src;
  assign pin_oe  = port_dir;

endmodule

// File: rtl/oc_compare_unit.sv
module oc_compare_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [1:0]       oc_mode,
  input  logic             force_oc,
  input  logic             flag_clr,
  input  logic             port_data,
  input  logic             port_dir,
  output logic [CNT_W-1:0] cmp_val,
  output logic             oc_state,
  output logic             match_flag,
  output logic             pin_out,
  output logic             pin_oe
);

  logic hit_evt;

  oc_match_gate #(.CNT_W(CNT_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cnt_val   (cnt_val),
    .cnt_wr    (cnt_wr),
    .cmp_wr    (cmp_wr),
    .cmp_wdata (cmp_wdata),
    .cmp_val   (cmp_val),
    .hit       (hit_evt)
  );

  oc_state_reg u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (oc_mode),
    .hit      (hit_evt),
    .force_oc (force_oc),
    .flag_clr (flag_clr),
    .oc_q     (oc_state),
    .flag_q   (match_flag)
  );

  oc_pin_mux u_mux (
    .mode      (oc_mode),
    .oc_q      (oc_state),
    .port_data (port_data),
    .port_dir  (port_dir),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

endmodule

// File: rtl/oc_compare_unit_chk.sv
module oc_compare_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic cnt_wr,
  input logic force_oc,
  input logic flag_clr,
  input logic port_dir,
  input logic pin_out,
  input logic pin_oe,
  input logic match_flag,
  input logic oc_state,
  input logic hit
);

  AST_FLAG_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(hit)); // R3

  AST_WR_BLOCKS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !hit); // R5

  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (force_oc && !hit && !match_flag) |=> !match_flag); // R6

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit) |=> !match_flag); // R7

  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> match_flag); // R7

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !port_dir |-> (!pin_out && !pin_oe)); // R9

  AST_OC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !force_oc) |=> $stable(oc_state)); // R10

endmodule

bind oc_compare_unit oc_compare_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_wr     (cnt_wr),
  .force_oc   (force_oc),
  .flag_clr   (flag_clr),
  .port_dir   (port_dir),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .match_flag (match_flag),
  .oc_state   (oc_state),
  .hit        (hit_evt)
);

// File: tb/test_oc_compare_unit.sv
`timescale 1ns/1ps
module test_oc_compare_unit;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic         cnt_wr = 1'b0;
  logic         cmp_wr = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic [1:0]   oc_mode = 2'b00;
  logic         force_oc = 1'b0;
  logic         flag_clr = 1'b0;
  logic         port_data = 1'b0;
  logic         port_dir = 1'b0;
  logic [W-1:0] cmp_val;
  logic         oc_state, match_flag, pin_out, pin_oe;

  int checks = 0;
  int fails = 0;
  logic exp_oc;

  always #2.5 clk = ~clk;

  oc_compare_unit #(.CNT_W(W)) i_oc_compare_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val), .cnt_wr(cnt_wr),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .oc_mode(oc_mode), .force_oc(force_oc),
    .flag_clr(flag_clr), .port_data(port_data), .port_dir(port_dir),
    .cmp_val(cmp_val), .oc_state(oc_state), .match_flag(match_flag),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic model_next(input logic [1:0] m, input logic cur);
    if (m == 2'd1) return !cur;
    if (m == 2'd2) return 1'b0;
    if (m == 2'd3) return 1'b1;
    return cur;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Preset the compare bit with a force pulse.
  task automatic preset(input logic v);
    oc_mode = v ? 2'd3 : 2'd2;
    force_oc = 1'b1;
    cyc();
    force_oc = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    cyc();
    flag_clr = 1'b0;
  endtask

  task automatic load_cmp(input logic [W-1:0] v);
    cmp_wdata = v;
    cmp_wr = 1'b1;
    cyc();
    cmp_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 oc", oc_state, 0);
    check("R1 flag", match_flag, 0);
    check("R1 cmp", cmp_val, 0);
    tick = 1'b1; cnt_val = 0; oc_mode = 2'd1;
    cyc(); tick = 1'b0;
    check("R1 no block after reset", match_flag, 1);
    clear_flag(); preset(1'b0);

    // R2 and R3: full sweep of compare vs counter, toggle mode
    exp_oc = 1'b0;
    oc_mode = 2'd1;
    for (int c = 0; c < 16; c++) begin
      load_cmp(c[W-1:0]);
      check("R2 cmp readback", cmp_val, c);
      for (int n = 0; n < 16; n++) begin
        cnt_val = n[W-1:0];
        cyc(); // no tick: never matches
        check("R3 no tick", match_flag, 0);
        tick = 1'b1;
        cyc();
        tick = 1'b0;
        if (n == c) exp_oc = !exp_oc;
        check("R3 flag", match_flag, (n == c) ? 1 : 0);
        check("R3 oc", oc_state, exp_oc);
        clear_flag();
      end
    end

    // R4: every mode from both starting values
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        load_cmp(4'd7);
        preset(s[0]);
        oc_mode = m[1:0];
        cnt_val = 4'd7; tick = 1'b1;
        cyc(); tick = 1'b0;
        check("R4 action", oc_state, model_next(m[1:0], s[0]));
        check("R4 flag", match_flag, 1);
        clear_flag();
      end
    end

    // R5: block with stopped timer
    preset(1'b0);
    oc_mode = 2'd1; load_cmp(4'd5); cnt_val = 4'd5;
    cnt_wr = 1'b1; cyc(); cnt_wr = 1'b0;
    repeat (3) cyc();
    tick = 1'b1; cyc(); tick = 1'b0;
    check("R5 blocked flag", match_flag, 0);
    check("R5 blocked oc", oc_state, 0);
    tick = 1'b1; cyc(); tick = 1'b0;
    check("R5 after window flag", match_flag, 1);
    check("R5 after window oc", oc_state, 1);
    clear_flag();
    // R5: write and tick in the same cycle, then next tick also blocked
    cnt_wr = 1'b1; tick = 1'b1; cyc(); cnt_wr = 1'b0;
    check("R5 same-cycle", match_flag, 0);
    cyc(); tick = 1'b0;
    check("R5 next tick", match_flag, 0);
    check("R5 oc held", oc_state, 1);
    tick = 1'b1; cyc(); tick = 1'b0;
    check("R5 resumes", match_flag, 1);
    clear_flag();

    // R6: force while a block is pending; no flag
    preset(1'b0);
    cnt_wr = 1'b1; cyc(); cnt_wr = 1'b0;
    oc_mode = 2'd3; force_oc = 1'b1; cyc(); force_oc = 1'b0;
    check("R6 force set", oc_state, 1);
    check("R6 no flag", match_flag, 0);
    oc_mode = 2'd1; force_oc = 1'b1; cyc(); force_oc = 1'b0;
    check("R6 force toggle", oc_state, 0);
    check("R6 no flag 2", match_flag, 0);
    tick = 1'b1; cnt_val = 4'd9; cyc(); tick = 1'b0; // consume window

    // R7: set wins over clear, then clear alone
    load_cmp(4'd2); cnt_val = 4'd2; oc_mode = 2'd0;
    tick = 1'b1; cyc();
    check("R7 set", match_flag, 1);
    flag_clr = 1'b1; cyc(); tick = 1'b0;
    check("R7 set wins", match_flag, 1);
    cyc(); flag_clr = 1'b0;
    check("R7 cleared", match_flag, 0);

    // R8, R9, R10: pin routing sweep
    for (int o = 0; o < 2; o++) begin
      preset(o[0]);
      for (int m = 0; m < 4; m++) begin
        for (int d = 0; d < 2; d++) begin
          for (int p = 0; p < 2; p++) begin
            oc_mode = m[1:0]; port_dir = d[0]; port_data = p[0];
            #1;
            check("R8 R9 pin_out", pin_out, d ? ((m != 0) ? o : p) : 0);
            check("R9 pin_oe", pin_oe, d);
            cyc();
            check("R10 oc kept", oc_state, o);
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule